// File: doc/BRIEF.md
# Load-Use Interlock and Operand Bypass Selector

This block decides, every cycle, where the two ALU operands of an in-order, single-issue, five-stage integer pipeline come from, and whether the front of the pipe must hold for a cycle. It compares the source register numbers of the instruction in decode and of the instruction in execute with the destination numbers of older instructions still in flight. It drives the operand multiplexers, the hold of the fetch stage and decode latch, and the clear of the execute control word. It is purely combinational, so its outputs settle within the cycle in which the pipeline registers present its inputs.

An ALU result is bypassed from the execute/memory latch straight to the instruction that follows. A result one slot older comes from the memory/writeback latch. A load has no value until after its memory access. A reader directly behind it therefore waits one cycle while an empty slot enters execute, and then takes the loaded value from the memory/writeback latch. The register file writes in the first half of a cycle and reads in the second half, so a reader three slots behind a writer needs no bypass. Store data is the second source and obeys the same rules.

Top module: `hazard_fwd_unit`

## Requirements
- R1: `stallFront` and `bubbleEx` are both 1 when `exIsLoad` is 1, `exRd` is nonzero, and `exRd` equals `idRs1` or `idRs2`. In every other case both are 0, so the two always agree.
- R2: `fwdSelA` is 2'b10 (bypass from the execute/memory latch) when `xmWe` is 1, `xmRd` is nonzero and `xmRd` equals `exRs1`.
- R3: `fwdSelA` is 2'b01 (bypass from the memory/writeback latch) when `mwWe` is 1, `mwRd` is nonzero, `mwRd` equals `exRs1`, and R2 does not apply.
- R4: When both latches match the same source, the execute/memory latch wins and the code is 2'b10.
- R5: Register number 0 never causes a bypass or a stall, whatever the write enables and the load flag are.
- R6: A latch whose write enable is 0 never causes a bypass. An instruction in execute that is not a load never causes a stall, even when its destination matches a decode source.
- R7: `fwdSelB` follows the same rules for `exRs2`, independently of operand A. This covers the data operand of a store that reads the register a load just before it writes.
- R8: When no rule above applies, the select code is 2'b00 (register file). The code 2'b11 never appears.
- R9: In a running instruction stream, a reader directly behind a load sees exactly one stall cycle. When it then reaches execute, the load sits in the memory/writeback latch, the reader gets code 2'b01, and the stall stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idRs1 | input | 5 | First source register of the instruction in decode |
| idRs2 | input | 5 | Second source register of the instruction in decode |
| exRs1 | input | 5 | First source register of the instruction in execute (ALU input A) |
| exRs2 | input | 5 | Second source register of the instruction in execute (ALU input B / store data) |
| exRd | input | 5 | Destination register of the instruction in execute |
| exIsLoad | input | 1 | The instruction in execute is a load |
| xmRd | input | 5 | Destination held in the execute/memory latch |
| xmWe | input | 1 | Register write enable held in the execute/memory latch |
| mwRd | input | 5 | Destination held in the memory/writeback latch |
| mwWe | input | 1 | Register write enable held in the memory/writeback latch |
| fwdSelA | output | 2 | ALU input A source: 00 register file, 10 execute/memory, 01 memory/writeback |
| fwdSelB | output | 2 | ALU input B source, same encoding |
| stallFront | output | 1 | Hold the PC and the fetch/decode latch |
| bubbleEx | output | 1 | Clear the control word entering execute |

## Verification
The hardest case to reach from the ports is the cycle after a load-use stall. The bubble must then sit in execute, the load in the execute/memory latch, and the stalled reader still in decode. One cycle later the reader must pick up the load's value from the memory/writeback latch. Fixed vectors cannot show that sequence. The bench therefore runs a small instruction stream through its own model of the pipeline registers. It uses its independently predicted stall to decide whether decode holds and an empty slot enters execute, so the post-stall ordering arises naturally and is checked every cycle. Fixed vectors cover register zero, disabled writes, the double-match priority and store-data reads.

// File: rtl/hzfw_pkg.sv
package hzfw_pkg;
  localparam int REG_W   = 5;
  localparam int NUM_OPS = 2;

  typedef enum logic [1:0] {
    SEL_RF = 2'b00,
    SEL_MW = 2'b01,
    SEL_XM = 2'b10
  } opSel_t;

  typedef struct packed {
    logic [NUM_OPS-1:0] xmHit;
    logic [NUM_OPS-1:0] mwHit;
    logic               loadUse;
  } hitStrobes_t;
endpackage

// File: rtl/hzfw_match.sv
module hzfw_match
  import hzfw_pkg::*;
#(
  parameter int RW = REG_W
) (
  input  logic [RW-1:0] idRs1,
  input  logic [RW-1:0] idRs2,
  input  logic [RW-1:0] exRs1,
  input  logic [RW-1:0] exRs2,
  input  logic [RW-1:0] exRd,
  input  logic          exIsLoad,
  input  logic [RW-1:0] xmRd,
  input  logic          xmWe,
  input  logic [RW-1:0] mwRd,
  input  logic          mwWe,
  output hitStrobes_t   hits
);
  localparam logic [RW-1:0] ZERO_REG = '0;

  logic [RW-1:0] exSrc [NUM_OPS];
  logic          xmLive;
  logic          mwLive;
  logic          ldLive;

  assign exSrc[0] = exRs1;
  assign exSrc[1] = exRs2;

  assign xmLive = xmWe && (xmRd != ZERO_REG);
  assign mwLive = mwWe && (mwRd != ZERO_REG);
  assign ldLive = exIsLoad && (exRd != ZERO_REG);

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_cmp
    assign hits.xmHit[i] = xmLive && (xmRd == exSrc[i]);
    assign hits.mwHit[i] = mwLive && (mwRd == exSrc[i]);
  end

  assign hits.loadUse = ldLive && ((exRd == idRs1) || (exRd == idRs2));
endmodule

// File: rtl/hzfw_ctrl.sv
module hzfw_ctrl
  import hzfw_pkg::*;
(
  input  hitStrobes_t hits,
  output logic [1:0]  fwdSelA,
  output logic [1:0]  fwdSelB,
  output logic        stallFront,
  output logic        bubbleEx
);
  opSel_t opSel [NUM_OPS];

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_sel
    always_comb begin
      if (hits.xmHit[i])      opSel[i] = SEL_XM;
      else if (hits.mwHit[i]) opSel[i] = SEL_MW;
      else                    opSel[i] = SEL_RF;
    end
  end

  assign fwdSelA    = opSel[0];
  assign fwdSelB    = opSel[1];
  assign stallFront = hits.loadUse;
  assign bubbleEx   = hits.loadUse;

  always_comb begin
    AST_SEL_LEGAL_A: assert (fwdSelA != 2'b11); // R8
    AST_SEL_LEGAL_B: assert (fwdSelB != 2'b11); // R8
    AST_NEWER_WINS: assert (!(hits.xmHit[0] && hits.mwHit[0]) || fwdSelA == SEL_XM); // R4
  end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hzfw_pkg::*;
#(
  parameter int RW = REG_W
) (
  input  logic [RW-1:0] idRs1,
  input  logic [RW-1:0] idRs2,
  input  logic [RW-1:0] exRs1,
  input  logic [RW-1:0] exRs2,
  input  logic [RW-1:0] exRd,
  input  logic          exIsLoad,
  input  logic [RW-1:0] xmRd,
  input  logic          xmWe,
  input  logic [RW-1:0] mwRd,
  input  logic          mwWe,
  output logic [1:0]    fwdSelA,
  output logic [1:0]    fwdSelB,
  output logic          stallFront,
  output logic          bubbleEx
);
  hitStrobes_t hits;

  hzfw_match #(.RW(RW)) u_match (
    .idRs1(idRs1), .idRs2(idRs2), .exRs1(exRs1), .exRs2(exRs2),
    .exRd(exRd), .exIsLoad(exIsLoad), .xmRd(xmRd), .xmWe(xmWe),
    .mwRd(mwRd), .mwWe(mwWe), .hits(hits)
  );

  hzfw_ctrl u_ctrl (
    .hits(hits), .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
    .stallFront(stallFront), .bubbleEx(bubbleEx)
  );

  always_comb begin
    AST_STALL_PAIR: assert (stallFront == bubbleEx); // R1
    AST_ZERO_A: assert (exRs1 != '0 || fwdSelA == 2'b00); // R5
    AST_ZERO_B: assert (exRs2 != '0 || fwdSelB == 2'b00); // R5
    AST_NOLOAD_NOSTALL: assert (exIsLoad || !stallFront); // R6
    AST_WE_GATE_A: assert (xmWe || mwWe || fwdSelA == 2'b00); // R6
  end
endmodule

// File: tb/sim_hazard_fwd_unit.sv
`timescale 1ns/1ps
module sim_hazard_fwd_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [4:0] idRs1, idRs2, exRs1, exRs2, exRd, xmRd, mwRd;
  logic       exIsLoad, xmWe, mwWe;
  logic [1:0] fwdSelA, fwdSelB;
  logic       stallFront, bubbleEx;

  hazard_fwd_unit u0 (
    .idRs1(idRs1), .idRs2(idRs2), .exRs1(exRs1), .exRs2(exRs2),
    .exRd(exRd), .exIsLoad(exIsLoad), .xmRd(xmRd), .xmWe(xmWe),
    .mwRd(mwRd), .mwWe(mwWe), .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
    .stallFront(stallFront), .bubbleEx(bubbleEx)
  );

  typedef struct packed { logic [1:0] a; logic [1:0] b; logic st; } exp_t;
  typedef struct packed { logic [4:0] rs1; logic [4:0] rs2; logic [4:0] rd; logic we; logic ld; } instr_t;

  exp_t  expQ[$];
  string tagQ[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;

  function automatic logic [1:0] refSel(logic [4:0] src, logic [4:0] xr, logic xw,
                                        logic [4:0] mr, logic mw);
    if (xw && xr != 0 && xr == src) return 2'b10;
    if (mw && mr != 0 && mr == src) return 2'b01;
    return 2'b00;
  endfunction

  task automatic checkOne(string tag, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // driver: set ports, push expected values
  task automatic applyVec(string tag, logic [4:0] i1, logic [4:0] i2, logic [4:0] e1,
                          logic [4:0] e2, logic [4:0] erd, logic eld, logic [4:0] xr,
                          logic xw, logic [4:0] mr, logic mw);
    exp_t e;
    @(posedge clk); #1;
    idRs1 = i1; idRs2 = i2; exRs1 = e1; exRs2 = e2; exRd = erd; exIsLoad = eld;
    xmRd = xr; xmWe = xw; mwRd = mr; mwWe = mw;
    e.a  = refSel(e1, xr, xw, mr, mw);
    e.b  = refSel(e2, xr, xw, mr, mw);
    e.st = eld && erd != 0 && (erd == i1 || erd == i2);
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (expQ.size() != 0) begin
      exp_t  e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checkOne(t, "fwdSelA", fwdSelA, e.a);
      checkOne(t, "fwdSelB", fwdSelB, e.b);
      checkOne(t, "stallFront", stallFront, e.st);
      checkOne(t, "bubbleEx", bubbleEx, e.st);
    end
  end

  instr_t prog[11];

  initial begin
    instr_t idI, exI, xmI, mwI;
    int pc;
    idRs1 = 0; idRs2 = 0; exRs1 = 0; exRs2 = 0; exRd = 0; exIsLoad = 0;
    xmRd = 0; xmWe = 0; mwRd = 0; mwWe = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // idle state: nothing in flight
    applyVec("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // EX/MEM bypass on A
    applyVec("R2", 1, 2, 3, 4, 9, 0, 3, 1, 0, 0);
    // MEM/WB bypass on A
    applyVec("R3", 1, 2, 7, 4, 9, 0, 5, 1, 7, 1);
    // both latches match both operands: newer wins
    applyVec("R4", 1, 2, 6, 6, 9, 0, 6, 1, 6, 1);
    // register zero everywhere, with enables and load flag set
    applyVec("R5", 0, 0, 0, 0, 0, 1, 0, 1, 0, 1);
    // write enables low: no bypass
    applyVec("R6", 1, 2, 8, 8, 9, 0, 8, 0, 8, 0);
    // non-load in EX matching decode: no stall
    applyVec("R6", 11, 12, 1, 2, 11, 0, 0, 0, 0, 0);
    // load-use on first decode source
    applyVec("R1", 13, 2, 1, 2, 13, 1, 0, 0, 0, 0);
    // store data (second source) reads the load just before it
    applyVec("R7", 0, 14, 1, 2, 14, 1, 0, 0, 0, 0);
    // B only from MEM/WB while A from EX/MEM
    applyVec("R7", 1, 2, 15, 16, 9, 0, 15, 1, 16, 1);
    // three-later reader: writers already retired
    applyVec("R8", 1, 2, 17, 18, 9, 0, 19, 1, 20, 1);

    // instruction stream {rs1, rs2, rd, we, ld}
    prog[0]  = '{5'd2, 5'd0, 5'd1, 1'b1, 1'b1}; // load r1
    prog[1]  = '{5'd1, 5'd7, 5'd5, 1'b1, 1'b0}; // uses r1 right after load
    prog[2]  = '{5'd5, 5'd5, 5'd6, 1'b1, 1'b0}; // uses r5 on both sides
    prog[3]  = '{5'd3, 5'd6, 5'd0, 1'b0, 1'b0}; // store, data r6
    prog[4]  = '{5'd6, 5'd0, 5'd4, 1'b1, 1'b1}; // load r4
    prog[5]  = '{5'd0, 5'd4, 5'd0, 1'b0, 1'b0}; // store data r4 after load
    prog[6]  = '{5'd4, 5'd4, 5'd0, 1'b1, 1'b0}; // writes r0
    prog[7]  = '{5'd0, 5'd0, 5'd9, 1'b1, 1'b0}; // reads r0
    prog[8]  = '{5'd1, 5'd9, 5'd3, 1'b1, 1'b0};
    prog[9]  = '{5'd3, 5'd3, 5'd3, 1'b1, 1'b0};
    prog[10] = '{5'd3, 5'd9, 5'd8, 1'b1, 1'b0};

    idI = '0; exI = '0; xmI = '0; mwI = '0; pc = 0;
    for (int cyc = 0; cyc < 24; cyc++) begin
      exp_t e;
      @(posedge clk); #1;
      idRs1 = idI.rs1; idRs2 = idI.rs2;
      exRs1 = exI.rs1; exRs2 = exI.rs2; exRd = exI.rd; exIsLoad = exI.ld;
      xmRd = xmI.rd; xmWe = xmI.we; mwRd = mwI.rd; mwWe = mwI.we;
      e.a  = refSel(exI.rs1, xmI.rd, xmI.we, mwI.rd, mwI.we);
      e.b  = refSel(exI.rs2, xmI.rd, xmI.we, mwI.rd, mwI.we);
      e.st = exI.ld && exI.rd != 0 && (exI.rd == idI.rs1 || exI.rd == idI.rs2);
      expQ.push_back(e);
      tagQ.push_back("R9");
      mwI = xmI;
      xmI = exI;
      if (e.st) exI = '0;
      else begin
        exI = idI;
        idI = (pc < 11) ? prog[pc] : '0;
        pc++;
      end
    end

    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule